// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns parallel characters into an asynchronous serial bit stream on one output line. Software hands it characters through a single holding register. The block moves each character into a shift register, adds a low start bit and a high stop bit, and sends the result least significant bit first. Each bit lasts one period of an external baud tick. Two character widths are available: a short one of `DATA_W-1` bits and a long one of `DATA_W` bits. With the default `DATA_W = 9`, these are 8 and 9 bits.

Each time the block is enabled, it first sends one character time of idle ones. On request it sends all-zero break characters back to back. When the request drops, it always sends an idle one before the next character. An invert control flips the line polarity. A holding-register-empty flag tells the producer when it can write again. An interrupt request can be gated from that flag. Parity and baud-rate division are done elsewhere.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, and whenever no character is being shifted, `txd` rests at the idle level (1 when `inv_out`=0), `buf_empty` is 1 after reset.
- R2: The first activity after `en` rises is a preamble of ones whose length equals one data frame (10 bits when `long_char`=0, 11 when 1), it starts on the first `tick` after enabling.
- R3: A data frame is a 0 start bit, then the data bits least significant first (8 bits when `long_char`=0, 9 bits when 1), then a 1 stop bit, each bit lasting one `tick` period.
- R4: `buf_empty` falls on a write (`wr`=1 while enabled and empty) and rises on the tick at which the holding register moves into the shift register, a write while full or while `en`=0 is ignored.
- R5: `irq` is 1 exactly when `en`, `irq_en` and `buf_empty` are all 1.
- R6: If the holding register is full when a frame's last bit ends, the next frame starts on the following tick with no idle gap.
- R7: A break character is all zeros with no start or stop bit, lasting 10 bits (`long_char`=0) or 11 bits (`long_char`=1), plus one more bit when `ext_break`=1.
- R8: While `brk_req` is 1, break characters follow one another without a gap and take precedence over a buffered character, which stays held.
- R9: After `brk_req` falls, the current break completes, then exactly one idle one is sent before any further character.
- R10: `inv_out`=1 inverts `txd` at every moment, including idle and break levels.
- R11: Dropping `en` stops any frame at once, returns `txd` to idle, discards the buffered character and re-arms the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Transmitter enable, low clears state |
| tick | input | 1 | One-cycle baud strobe, one per bit time |
| wr | input | 1 | Write strobe for the holding register |
| wdata | input | DATA_W | Character to send (low bits used in short mode) |
| long_char | input | 1 | 0: short characters, 1: long characters |
| ext_break | input | 1 | Lengthens break characters by one bit |
| brk_req | input | 1 | Send break characters while high |
| irq_en | input | 1 | Interrupt enable for the empty flag |
| inv_out | input | 1 | Invert the serial output |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register can accept a character |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its default `DATA_W = 9`. This gives both character widths, 8 and 9 data bits. It also gives every break length from 10 to 12 bits, so all combinations of the width and extended-break controls can be checked against exact bit counts. The shift register is 12 bits wide under this default. The longest break therefore fills it completely, and the shift-in-ones edge is exercised as well.

// File: rtl/utx_pkg.sv
// Package utx_pkg
// Shared types for the serial transmitter: shifter states and the choice
// made at a character boundary. Assumes nothing beyond the compiler.
package utx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_BRK,
        ST_TRAIL
    } utx_state_e;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_PRE,
        CH_BRK,
        CH_TRAIL,
        CH_DATA
    } utx_choice_e;

endpackage

// File: rtl/utx_hold_buf.sv
// Module utx_hold_buf
// One-entry holding register in front of the shifter. A write is accepted
// only while enabled and empty. The entry is released when the shifter
// takes it. Assumes take is only raised while the entry is full.
module utx_hold_buf #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: accept a write while empty, release the entry on take.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (wr && !full_q) begin
            full_q <= 1'b1;
            data_q <= wdata;
        end
    end

    assign full = full_q;
    assign data = data_q;

    AST_FULL_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && full_q && wr && !take) |=> $stable(data_q)); // R4

    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && take) |=> !full_q); // R4

endmodule

// File: rtl/utx_shift_engine.sv
// Module utx_shift_engine
// Shift register and bit counter that produce preamble, data frames,
// break characters and the idle one that follows a break. At each
// character boundary it picks the next item in this order: preamble,
// break, trailing one, buffered data, idle. Assumes tick is a one-cycle
// strobe.
module utx_shift_engine
    import utx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              long_char,
    input  logic              ext_break,
    input  logic              brk_req,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take,
    output logic              raw_bit
);

    localparam int SR_W  = DATA_W + 3;
    localparam int CNT_W = $clog2(SR_W + 1);

    utx_state_e       state_q;
    utx_choice_e      choice;
    logic [SR_W-1:0]  sr_q;
    logic [SR_W-1:0]  frame_img;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] brk_len;
    logic             pre_pend_q;
    logic             slot_end;

    // Purpose: frame and break lengths for the current width mode.
    always_comb begin
        frame_len = long_char ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
        brk_len   = frame_len + CNT_W'(ext_break);
    end

    // Purpose: build the framed image, start at bit 0, stop above the data.
    always_comb begin
        frame_img    = '1;
        frame_img[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < DATA_W - 1 || long_char) begin
                frame_img[i+1] = buf_data[i];
            end
        end
    end

    // Purpose: pick what to load when the current item ends.
    always_comb begin
        slot_end = (state_q == ST_IDLE) || (cnt_q == CNT_W'(1));
        if (pre_pend_q)              choice = CH_PRE;
        else if (brk_req)            choice = CH_BRK;
        else if (state_q == ST_BRK)  choice = CH_TRAIL;
        else if (buf_full)           choice = CH_DATA;
        else                         choice = CH_IDLE;
        take = en && tick && slot_end && (choice == CH_DATA);
    end

    // Purpose: load a new item at a boundary or shift one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q    <= ST_IDLE;
            sr_q       <= '1;
            cnt_q      <= '0;
            pre_pend_q <= 1'b1;
        end else if (tick) begin
            if (slot_end) begin
                case (choice)
                    CH_PRE: begin
                        state_q    <= ST_PRE;
                        sr_q       <= '1;
                        cnt_q      <= frame_len;
                        pre_pend_q <= 1'b0;
                    end
                    CH_BRK: begin
                        state_q <= ST_BRK;
                        sr_q    <= '0;
                        cnt_q   <= brk_len;
                    end
                    CH_TRAIL: begin
                        state_q <= ST_TRAIL;
                        sr_q    <= '1;
                        cnt_q   <= CNT_W'(1);
                    end
                    CH_DATA: begin
                        state_q <= ST_DATA;
                        sr_q    <= frame_img;
                        cnt_q   <= frame_len;
                    end
                    default: begin
                        state_q <= ST_IDLE;
                        sr_q    <= '1;
                        cnt_q   <= '0;
                    end
                endcase
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
                sr_q  <= {1'b1, sr_q[SR_W-1:1]};
            end
        end
    end

    assign raw_bit = sr_q[0];

    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK) |-> !raw_bit); // R7

    AST_TRAIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |-> raw_bit); // R9

    AST_BRK_TO_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && state_q == ST_BRK && cnt_q == CNT_W'(1) && !brk_req)
        |=> (state_q == ST_TRAIL)); // R9

    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SR_W)); // R7

endmodule

// File: rtl/utx_line_drive.sv
// Module utx_line_drive
// Final output stage: forces idle while disabled and applies the
// polarity control. Assumes raw_bit is already the idle one between items.
module utx_line_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inv_out,
    input  logic raw_bit,
    output logic txd
);

    // Purpose: idle when disabled, then optional inversion.
    always_comb begin
        txd = (raw_bit | ~en) ^ inv_out;
    end

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (txd == !inv_out)); // R11

endmodule

// File: rtl/uart_brk_tx.sv
// Module uart_brk_tx
// Top of the asynchronous serial transmitter: holding register, shifter
// with preamble and break support, output stage and interrupt gating.
// Assumes tick pulses for one clock per bit time and that writes come
// from one producer.
module uart_brk_tx #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              long_char,
    input  logic              ext_break,
    input  logic              brk_req,
    input  logic              irq_en,
    input  logic              inv_out,
    output logic              txd,
    output logic              buf_empty,
    output logic              irq
);

    logic              full;
    logic              take;
    logic              raw_bit;
    logic [DATA_W-1:0] hold_data;

    utx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wr    (wr),
        .wdata (wdata),
        .take  (take),
        .full  (full),
        .data  (hold_data)
    );

    utx_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .long_char (long_char),
        .ext_break (ext_break),
        .brk_req   (brk_req),
        .buf_full  (full),
        .buf_data  (hold_data),
        .take      (take),
        .raw_bit   (raw_bit)
    );

    utx_line_drive u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .inv_out (inv_out),
        .raw_bit (raw_bit),
        .txd     (txd)
    );

    // Purpose: empty flag and gated interrupt request.
    always_comb begin
        buf_empty = ~full;
        irq       = en & irq_en & ~full;
    end

endmodule

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;

    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          tick = 1'b0;
    logic          wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          long_char = 1'b0;
    logic          ext_break = 1'b0;
    logic          brk_req = 1'b0;
    logic          irq_en = 1'b0;
    logic          inv_out = 1'b0;
    logic          txd;
    logic          buf_empty;
    logic          irq;

    int    checks = 0;
    int    fails = 0;
    int    pend = 0;
    bit    tick_q = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    uart_brk_tx #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .wr(wr),
        .wdata(wdata), .long_char(long_char), .ext_break(ext_break),
        .brk_req(brk_req), .irq_en(irq_en), .inv_out(inv_out),
        .txd(txd), .buf_empty(buf_empty), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver side: expected line levels pushed into the scoreboard
    task automatic push_bit(input bit b, input string tag);
        exp_q.push_back(b ^ inv_out);
        tag_q.push_back(tag);
        pend++;
    endtask

    task automatic push_run(input bit b, input int n, input string tag);
        for (int i = 0; i < n; i++) push_bit(b, tag);
    endtask

    task automatic push_frame(input int d, input bit nine, input string tag);
        push_bit(1'b0, tag);
        for (int i = 0; i < (nine ? 9 : 8); i++) push_bit(d[i], tag);
        push_bit(1'b1, tag);
    endtask

    task automatic go(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        pend -= n;
    endtask

    task automatic flush();
        go(pend);
    endtask

    task automatic write(input int d);
        @(negedge clk) begin wr = 1'b1; wdata = DW'(d); end
        @(negedge clk) wr = 1'b0;
    endtask

    // monitor: one scoreboard entry per tick, compared after the edge
    always @(posedge clk) tick_q <= tick;

    always @(negedge clk) begin
        if (tick_q) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected tick", txd, 1);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(txd == e, {t, " line bit"}, txd, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(buf_empty == 1'b1, "R1 reset empty", buf_empty, 1);
        chk(irq == 1'b0, "R5 irq while disabled", irq, 0);

        // R2 preamble then R3 short frame, R4/R5 flag timing
        en = 1'b1; irq_en = 1'b1;
        write(8'hA5);
        chk(buf_empty == 1'b0, "R4 write clears empty", buf_empty, 0);
        chk(irq == 1'b0, "R5 irq low when full", irq, 0);
        push_run(1'b1, 10, "R2");
        go(10);
        chk(buf_empty == 1'b0, "R2 data held during preamble", buf_empty, 0);
        push_frame(8'hA5, 1'b0, "R3");
        push_bit(1'b1, "R1");
        go(1);
        chk(buf_empty == 1'b1, "R4 empty on transfer", buf_empty, 1);
        chk(irq == 1'b1, "R5 irq on empty", irq, 1);
        flush();

        // R4 write while full is ignored
        write(8'h3C);
        write(8'hFF);
        push_frame(8'h3C, 1'b0, "R4");
        push_run(1'b1, 2, "R1");
        flush();

        // R3 long characters
        long_char = 1'b1;
        write(9'h15A);
        push_frame(9'h15A, 1'b1, "R3");
        push_bit(1'b1, "R1");
        flush();
        long_char = 1'b0;

        // R6 back-to-back characters
        write(8'h11);
        push_frame(8'h11, 1'b0, "R6");
        push_frame(8'h22, 1'b0, "R6");
        push_bit(1'b1, "R1");
        go(1);
        write(8'h22);
        chk(buf_empty == 1'b0, "R6 refill accepted", buf_empty, 0);
        flush();

        // R8 repeated breaks with a pending character, R9 trailing one
        brk_req = 1'b1;
        push_run(1'b0, 20, "R8");
        push_bit(1'b1, "R9");
        push_frame(8'h81, 1'b0, "R9");
        push_bit(1'b1, "R1");
        go(2);
        write(8'h81);
        go(10);
        chk(buf_empty == 1'b0, "R8 character held during break", buf_empty, 0);
        brk_req = 1'b0;
        flush();

        // R7 break lengths for the other mode combinations
        for (int m = 1; m < 4; m++) begin
            long_char = m[1];
            ext_break = m[0];
            brk_req = 1'b1;
            push_run(1'b0, 10 + m[1] + m[0], "R7");
            push_bit(1'b1, "R9");
            push_bit(1'b1, "R1");
            go(1);
            brk_req = 1'b0;
            flush();
        end
        long_char = 1'b0; ext_break = 1'b0;

        // R10 inverted output
        @(negedge clk) inv_out = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R10 inverted idle", txd, 0);
        write(8'h0F);
        push_frame(8'h0F, 1'b0, "R10");
        push_bit(1'b1, "R10");
        flush();
        brk_req = 1'b1;
        push_run(1'b0, 10, "R10");
        push_bit(1'b1, "R10");
        push_bit(1'b1, "R10");
        go(1);
        brk_req = 1'b0;
        flush();
        @(negedge clk) inv_out = 1'b0;

        // R5 interrupt gating
        @(negedge clk) irq_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R5 irq masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R5 irq unmasked", irq, 1);

        // R11 abort mid-frame, ignored write while disabled, preamble again
        write(8'h00);
        push_run(1'b0, 3, "R11");
        go(3);
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R11 idle when disabled", txd, 1);
        chk(buf_empty == 1'b1, "R11 empty when disabled", buf_empty, 1);
        chk(irq == 1'b0, "R5 irq gated by enable", irq, 0);
        write(8'h77);
        chk(buf_empty == 1'b1, "R4 write ignored while disabled", buf_empty, 1);
        @(negedge clk) en = 1'b1;
        @(negedge clk);
        chk(buf_empty == 1'b1, "R11 buffer discarded", buf_empty, 1);
        write(8'h55);
        push_run(1'b1, 10, "R11");
        push_frame(8'h55, 1'b0, "R11");
        push_bit(1'b1, "R1");
        flush();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule